// File: doc/BRIEF.md
# Indirect Register Access Engine for a Management Bus

This block is a management-bus master for a target that holds many 16-bit register sets behind one bus address. A client hands it one request at a time: read or write, a 5-bit device address, a 5-bit register address and, for writes, 16 bits of data. The engine turns that request into a short run of raw clause-22 frames on an abstract transaction port, and the bit-level serializer sits behind that port. The engine returns the read data or an error flag.

When the configured bus address is non-zero, the target is reached through a two-register window at that address: a command register at offset 0 and a data register at offset 1. The engine polls the busy flag of the command register before and after it issues a command. Polls that fail are retried at a fixed spacing set by a prescaler parameter, and the request ends with an error once the attempt limit is used up. When the configured bus address is zero, the window is bypassed: one raw frame goes straight to bus address = device address and register = register address.

Top module: `smi_indirect_engine`

## Requirements
- R1: After reset, and whenever no request is in progress, `req_ready` is 1, `mdio_valid` is 0 and `rsp_done` is 0.
- R2: When `cfg_bus_addr` is 0 at acceptance, exactly one raw frame is issued, with phy = device address, register = register address, the request's write flag and write data. A read returns that frame's data.
- R3: In window mode every raw frame goes to phy = `cfg_bus_addr`, and the register is 0 for the command register or 1 for the data register. The command word has bit 15 = 1 (start/busy) and bit 12 = 1 (clause 22). Bits 11:10 hold the opcode, 2 for read and 1 for write. Bits 9:5 hold the device and bits 4:0 the register, and bits 14:13 are 0. A frame's fields stay stable while `mdio_valid` is high until `mdio_done`.
- R4: A window read issues, in order: busy poll (read of register 0), command write, busy poll, data read (read of register 1). The data read result is returned as `rsp_rdata`.
- R5: A window write issues, in order: busy poll, data write (register 1 with the request's data), command write, busy poll.
- R6: A poll attempt succeeds only if `mdio_err` is 0 and bit 15 of `mdio_rdata` is 0. Any other poll result counts as a failed attempt and is retried.
- R7: After a failed attempt that is not the last, the next poll frame is raised exactly `TICKS_PER_MS` clock edges after the edge that took the failed `mdio_done`.
- R8: When `POLL_LIMIT` consecutive attempts in one poll phase fail, the request ends with `rsp_error` = 1 straight after the last failure, and no further raw frame is issued for it.
- R9: A raw error (`mdio_err` = 1) on a command write, data write, data read or direct frame ends the request with `rsp_error` = 1, and no further raw frame is issued for it.
- R10: Only one request is in progress at a time. `req_ready` is 0 from the edge after acceptance through the cycle in which `rsp_done` is high. A `req_valid` presented while `req_ready` is 0 is ignored and causes no raw frame.
- R11: `rsp_done` is a one-cycle pulse. `rsp_rdata` carries the read data on a successful read and is 0 for writes and errors. `req_ready` returns to 1 in the cycle after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_bus_addr | input | 5 | Target bus address; 0 selects direct access |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, accepts a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dev | input | 5 | Device (register set) address |
| req_reg | input | 5 | Register address within the set |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_error | output | 1 | Request failed (timeout or raw error), valid with `rsp_done` |
| rsp_rdata | output | 16 | Read data, valid with `rsp_done` |
| mdio_valid | output | 1 | Raw frame request, held until `mdio_done` |
| mdio_write | output | 1 | Raw frame is a write |
| mdio_phy | output | 5 | Raw frame phy address |
| mdio_reg | output | 5 | Raw frame register address |
| mdio_wdata | output | 16 | Raw frame write data |
| mdio_done | input | 1 | Raw frame finished (one cycle) |
| mdio_err | input | 1 | Raw frame failed, valid with `mdio_done` |
| mdio_rdata | input | 16 | Raw frame read data, valid with `mdio_done` |

## Verification
The first raw frame rises one edge after the request is accepted, and each following frame rises one edge after the previous frame's `mdio_done`. A retry frame after a failed poll rises `TICKS_PER_MS` edges after that `mdio_done`, and `rsp_done` rises one edge after the final `mdio_done`. The bench's target model stamps each frame with the cycle of its first visible `mdio_valid` and of its `mdio_done`, so the retry spacing is compared as an exact difference of these stamps. The bench drives and samples only on falling edges. The response is read in the falling-edge slot where `rsp_done` is first high, and the following slot is used to confirm that the pulse has ended and that `req_ready` is back.

// File: rtl/smi_ind_pkg.sv
package smi_ind_pkg;

    localparam int ADDR_W = 5;
    localparam int DATA_W = 16;
    localparam int BUSY_BIT = 15;

    localparam logic [ADDR_W-1:0] WIN_CMD_OFS  = 5'd0;
    localparam logic [ADDR_W-1:0] WIN_DATA_OFS = 5'd1;

    localparam logic [1:0] OPC_WRITE = 2'd1;
    localparam logic [1:0] OPC_READ  = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIRECT,
        ST_POLL,
        ST_GAP,
        ST_DATA_WR,
        ST_CMD_WR,
        ST_DATA_RD,
        ST_RESP
    } seq_state_t;

    typedef enum logic {
        PH_BEFORE,
        PH_AFTER
    } poll_phase_t;

    typedef struct packed {
        logic              write;
        logic [ADDR_W-1:0] dev;
        logic [ADDR_W-1:0] regn;
        logic [DATA_W-1:0] wdata;
    } access_req_t;

    typedef struct packed {
        logic              write;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regn;
        logic [DATA_W-1:0] wdata;
    } raw_frame_t;

    function automatic logic [DATA_W-1:0] build_cmd_word(
        input logic              write,
        input logic [ADDR_W-1:0] dev,
        input logic [ADDR_W-1:0] regn
    );
        logic [1:0] opc;
        opc = write ? OPC_WRITE : OPC_READ;
        return {1'b1, 2'b00, 1'b1, opc, dev, regn};
    endfunction

    function automatic logic poll_clear(
        input logic              err,
        input logic [DATA_W-1:0] rdata
    );
        return !err && !rdata[BUSY_BIT];
    endfunction

endpackage

// File: rtl/smi_gap_timer.sv
module smi_gap_timer #(
    parameter int TICKS = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic expired
);
    localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= CW'(TICKS - 1);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/smi_attempt_counter.sv
module smi_attempt_counter #(
    parameter int LIMIT = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic bump,
    output logic final_try
);
    localparam int AW = $clog2(LIMIT + 1);

    logic [AW-1:0] tries;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            tries <= '0;
        end else if (bump) begin
            tries <= tries + 1'b1;
        end
    end

    assign final_try = (tries >= AW'(LIMIT - 1));
endmodule

// File: rtl/smi_frame_builder.sv
module smi_frame_builder
    import smi_ind_pkg::*;
(
    input  seq_state_t        state,
    input  access_req_t       req,
    input  logic [ADDR_W-1:0] bus_addr,
    output raw_frame_t        frame
);
    always_comb begin
        frame = '0;
        unique case (state)
            ST_DIRECT: begin
                frame.write = req.write;
                frame.phy   = req.dev;
                frame.regn  = req.regn;
                frame.wdata = req.write ? req.wdata : '0;
            end
            ST_POLL: begin
                frame.phy  = bus_addr;
                frame.regn = WIN_CMD_OFS;
            end
            ST_DATA_WR: begin
                frame.write = 1'b1;
                frame.phy   = bus_addr;
                frame.regn  = WIN_DATA_OFS;
                frame.wdata = req.wdata;
            end
            ST_CMD_WR: begin
                frame.write = 1'b1;
                frame.phy   = bus_addr;
                frame.regn  = WIN_CMD_OFS;
                frame.wdata = build_cmd_word(req.write, req.dev, req.regn);
            end
            ST_DATA_RD: begin
                frame.phy  = bus_addr;
                frame.regn = WIN_DATA_OFS;
            end
            default: frame = '0;
        endcase
    end
endmodule

// File: rtl/smi_indirect_engine.sv
module smi_indirect_engine
    import smi_ind_pkg::*;
#(
    parameter int TICKS_PER_MS = 100000,
    parameter int POLL_LIMIT   = 100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [4:0]        cfg_bus_addr,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [4:0]        req_dev,
    input  logic [4:0]        req_reg,
    input  logic [15:0]       req_wdata,
    output logic              rsp_done,
    output logic              rsp_error,
    output logic [15:0]       rsp_rdata,
    output logic              mdio_valid,
    output logic              mdio_write,
    output logic [4:0]        mdio_phy,
    output logic [4:0]        mdio_reg,
    output logic [15:0]       mdio_wdata,
    input  logic              mdio_done,
    input  logic              mdio_err,
    input  logic [15:0]       mdio_rdata
);
    seq_state_t        state;
    poll_phase_t       phase;
    access_req_t       req_q;
    logic [ADDR_W-1:0] bus_q;
    logic              err_q;
    logic [DATA_W-1:0] rdata_q;
    raw_frame_t        frame;

    logic accept;
    logic frame_end;
    logic poll_good;
    logic gap_load;
    logic gap_expired;
    logic try_clear;
    logic try_bump;
    logic final_try;

    assign accept    = req_valid && (state == ST_IDLE);
    assign frame_end = mdio_valid && mdio_done;
    assign poll_good = poll_clear(mdio_err, mdio_rdata);

    assign gap_load  = (state == ST_POLL) && frame_end && !poll_good && !final_try;
    assign try_bump  = gap_load;
    assign try_clear = accept || ((state == ST_POLL) && frame_end && poll_good);

    smi_gap_timer #(.TICKS(TICKS_PER_MS)) u_gap (
        .clk     (clk),
        .rst     (rst),
        .load    (gap_load),
        .expired (gap_expired)
    );

    smi_attempt_counter #(.LIMIT(POLL_LIMIT)) u_tries (
        .clk       (clk),
        .rst       (rst),
        .clear     (try_clear),
        .bump      (try_bump),
        .final_try (final_try)
    );

    smi_frame_builder u_build (
        .state    (state),
        .req      (req_q),
        .bus_addr (bus_q),
        .frame    (frame)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            phase   <= PH_BEFORE;
            req_q   <= '0;
            bus_q   <= '0;
            err_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        req_q   <= '{write: req_write, dev: req_dev,
                                     regn: req_reg, wdata: req_wdata};
                        bus_q   <= cfg_bus_addr;
                        err_q   <= 1'b0;
                        rdata_q <= '0;
                        phase   <= PH_BEFORE;
                        state   <= (cfg_bus_addr == '0) ? ST_DIRECT : ST_POLL;
                    end
                end
                ST_DIRECT: begin
                    if (frame_end) begin
                        err_q <= mdio_err;
                        if (!req_q.write && !mdio_err) begin
                            rdata_q <= mdio_rdata;
                        end
                        state <= ST_RESP;
                    end
                end
                ST_POLL: begin
                    if (frame_end) begin
                        if (poll_good) begin
                            if (phase == PH_BEFORE) begin
                                state <= req_q.write ? ST_DATA_WR : ST_CMD_WR;
                            end else begin
                                state <= req_q.write ? ST_RESP : ST_DATA_RD;
                            end
                        end else if (final_try) begin
                            err_q <= 1'b1;
                            state <= ST_RESP;
                        end else begin
                            state <= ST_GAP;
                        end
                    end
                end
                ST_GAP: begin
                    if (gap_expired) begin
                        state <= ST_POLL;
                    end
                end
                ST_DATA_WR: begin
                    if (frame_end) begin
                        if (mdio_err) begin
                            err_q <= 1'b1;
                            state <= ST_RESP;
                        end else begin
                            state <= ST_CMD_WR;
                        end
                    end
                end
                ST_CMD_WR: begin
                    if (frame_end) begin
                        if (mdio_err) begin
                            err_q <= 1'b1;
                            state <= ST_RESP;
                        end else begin
                            phase <= PH_AFTER;
                            state <= ST_POLL;
                        end
                    end
                end
                ST_DATA_RD: begin
                    if (frame_end) begin
                        if (mdio_err) begin
                            err_q <= 1'b1;
                        end else begin
                            rdata_q <= mdio_rdata;
                        end
                        state <= ST_RESP;
                    end
                end
                ST_RESP: begin
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign req_ready  = (state == ST_IDLE);
    assign rsp_done   = (state == ST_RESP);
    assign rsp_error  = err_q;
    assign rsp_rdata  = rdata_q;

    assign mdio_valid = (state == ST_DIRECT) || (state == ST_POLL) ||
                        (state == ST_DATA_WR) || (state == ST_CMD_WR) ||
                        (state == ST_DATA_RD);
    assign mdio_write = frame.write;
    assign mdio_phy   = frame.phy;
    assign mdio_reg   = frame.regn;
    assign mdio_wdata = frame.wdata;
endmodule

// File: rtl/smi_indirect_engine_chk.sv
module smi_indirect_engine_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic        rsp_done,
    input logic        mdio_valid,
    input logic        mdio_write,
    input logic [4:0]  mdio_phy,
    input logic [4:0]  mdio_reg,
    input logic [15:0] mdio_wdata,
    input logic        mdio_done
);
    // R1: no raw frame while idle
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !mdio_valid);

    // R3: frame fields held until the frame finishes
    p_frame_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (mdio_valid && !mdio_done) |=>
            (mdio_valid && $stable(mdio_write) && $stable(mdio_phy) &&
             $stable(mdio_reg) && $stable(mdio_wdata)));

    // R10: acceptance drops ready on the next cycle
    p_accept_busy_r10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R10: ready stays low in the response cycle
    p_done_not_ready_r10: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> !req_ready);

    // R11: done is a single-cycle pulse followed by ready
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> (!rsp_done && req_ready));
endmodule

bind smi_indirect_engine smi_indirect_engine_chk u_chk (.*);

// File: tb/smi_indirect_engine_test.sv
`timescale 1ns/1ps
module smi_indirect_engine_test;
    localparam int TICKS = 8;
    localparam int LIMIT = 100;
    localparam int LAT   = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  cfg_bus_addr = 5'd0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [4:0]  req_dev = '0;
    logic [4:0]  req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic        rsp_done;
    logic        rsp_error;
    logic [15:0] rsp_rdata;
    logic        mdio_valid;
    logic        mdio_write;
    logic [4:0]  mdio_phy;
    logic [4:0]  mdio_reg;
    logic [15:0] mdio_wdata;
    logic        mdio_done = 1'b0;
    logic        mdio_err = 1'b0;
    logic [15:0] mdio_rdata = '0;

    smi_indirect_engine #(.TICKS_PER_MS(TICKS), .POLL_LIMIT(LIMIT)) uut (
        .clk(clk), .rst(rst), .cfg_bus_addr(cfg_bus_addr),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_dev(req_dev), .req_reg(req_reg), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_error(rsp_error), .rsp_rdata(rsp_rdata),
        .mdio_valid(mdio_valid), .mdio_write(mdio_write), .mdio_phy(mdio_phy),
        .mdio_reg(mdio_reg), .mdio_wdata(mdio_wdata), .mdio_done(mdio_done),
        .mdio_err(mdio_err), .mdio_rdata(mdio_rdata)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // target model
    logic [15:0] tmem [0:1023];
    logic [15:0] win_cmd = '0;
    logic [15:0] win_data = '0;
    int busy_left = 0;
    int busy_after_cmd = 0;
    int err_polls = 0;
    bit err_data_wr = 1'b0;

    // frame log
    int          lg_n = 0;
    bit          lg_w   [0:255];
    logic [4:0]  lg_phy [0:255];
    logic [4:0]  lg_reg [0:255];
    logic [15:0] lg_wd  [0:255];
    int          lg_start [0:255];
    int          lg_end   [0:255];

    initial begin
        for (int i = 0; i < 1024; i++) tmem[i] = '0;
    end

    initial begin : responder
        int cnt;
        int st;
        cnt = 0;
        st = 0;
        forever begin
            @(negedge clk);
            if (mdio_done) begin
                mdio_done = 1'b0;
                mdio_err = 1'b0;
                cnt = 0;
            end else if (mdio_valid) begin
                if (cnt == 0) st = cyc;
                if (cnt == LAT) begin
                    mdio_err = 1'b0;
                    mdio_rdata = '0;
                    if (cfg_bus_addr == 5'd0) begin
                        if (mdio_write) tmem[{mdio_phy, mdio_reg}] = mdio_wdata;
                        else mdio_rdata = tmem[{mdio_phy, mdio_reg}];
                    end else if (mdio_reg == 5'd0) begin
                        if (mdio_write) begin
                            win_cmd = mdio_wdata;
                            if (mdio_wdata[11:10] == 2'd2)
                                win_data = tmem[mdio_wdata[9:0]];
                            else if (mdio_wdata[11:10] == 2'd1)
                                tmem[mdio_wdata[9:0]] = win_data;
                            busy_left = busy_after_cmd;
                        end else if (err_polls > 0) begin
                            mdio_err = 1'b1;
                            err_polls--;
                        end else begin
                            mdio_rdata = {busy_left > 0, win_cmd[14:0]};
                            if (busy_left > 0) busy_left--;
                        end
                    end else begin
                        if (mdio_write) begin
                            if (err_data_wr) mdio_err = 1'b1;
                            else win_data = mdio_wdata;
                        end else begin
                            mdio_rdata = win_data;
                        end
                    end
                    if (lg_n < 256) begin
                        lg_w[lg_n] = mdio_write;
                        lg_phy[lg_n] = mdio_phy;
                        lg_reg[lg_n] = mdio_reg;
                        lg_wd[lg_n] = mdio_wdata;
                        lg_start[lg_n] = st;
                        lg_end[lg_n] = cyc;
                    end
                    lg_n++;
                    mdio_done = 1'b1;
                end else begin
                    cnt++;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_frame(input int i, input bit w, input logic [4:0] phy,
                             input logic [4:0] rg, input logic [15:0] wd,
                             input string req);
        chk(lg_w[i] == w, req, $sformatf("frame %0d write", i), lg_w[i], w);
        chk(lg_phy[i] == phy, req, $sformatf("frame %0d phy", i), lg_phy[i], phy);
        chk(lg_reg[i] == rg, req, $sformatf("frame %0d reg", i), lg_reg[i], rg);
        if (w) chk(lg_wd[i] == wd, req, $sformatf("frame %0d data", i), lg_wd[i], wd);
    endtask

    task automatic do_req(input bit w, input logic [4:0] d, input logic [4:0] r,
                          input logic [15:0] wd, output bit err,
                          output logic [15:0] rd);
        int n;
        bit ready_bad;
        lg_n = 0;
        ready_bad = 1'b0;
        @(negedge clk);
        req_write = w; req_dev = d; req_reg = r; req_wdata = wd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!rsp_done && n < 20000) begin
            if (req_ready) ready_bad = 1'b1;
            @(negedge clk);
            n++;
        end
        err = rsp_error;
        rd = rsp_rdata;
        chk(!ready_bad && !req_ready, "R10", "ready low while busy", ready_bad, 0);
        @(negedge clk);
        chk(!rsp_done && req_ready, "R11", "done pulse ends, ready back",
            {rsp_done, req_ready}, 2'b01);
    endtask

    task automatic t_reset();
        chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
        chk(mdio_valid == 1'b0, "R1", "no frame after reset", mdio_valid, 0);
        chk(rsp_done == 1'b0, "R1", "no done after reset", rsp_done, 0);
    endtask

    task automatic t_direct();
        bit e; logic [15:0] rd;
        cfg_bus_addr = 5'd0;
        do_req(1'b1, 5'd9, 5'd4, 16'h1234, e, rd);
        chk(lg_n == 1, "R2", "direct write frame count", lg_n, 1);
        chk_frame(0, 1'b1, 5'd9, 5'd4, 16'h1234, "R2");
        chk(!e && rd == 16'h0, "R11", "direct write rdata zero", rd, 0);
        do_req(1'b0, 5'd9, 5'd4, 16'h0, e, rd);
        chk(lg_n == 1, "R2", "direct read frame count", lg_n, 1);
        chk_frame(0, 1'b0, 5'd9, 5'd4, 16'h0, "R2");
        chk(!e && rd == 16'h1234, "R2", "direct read data", rd, 16'h1234);
    endtask

    task automatic t_win_write();
        bit e; logic [15:0] rd;
        cfg_bus_addr = 5'h12;
        do_req(1'b1, 5'd3, 5'd7, 16'hA5C3, e, rd);
        chk(lg_n == 4, "R5", "window write frame count", lg_n, 4);
        chk_frame(0, 1'b0, 5'h12, 5'd0, 16'h0, "R5");
        chk_frame(1, 1'b1, 5'h12, 5'd1, 16'hA5C3, "R5");
        chk_frame(2, 1'b1, 5'h12, 5'd0, 16'h9467, "R3");
        chk_frame(3, 1'b0, 5'h12, 5'd0, 16'h0, "R5");
        chk(!e && rd == 16'h0, "R11", "window write rdata zero", {e, rd}, 0);
        chk(tmem[{5'd3, 5'd7}] == 16'hA5C3, "R5", "target written",
            tmem[{5'd3, 5'd7}], 16'hA5C3);
    endtask

    task automatic t_win_read();
        bit e; logic [15:0] rd;
        cfg_bus_addr = 5'h12;
        do_req(1'b0, 5'd3, 5'd7, 16'h0, e, rd);
        chk(lg_n == 4, "R4", "window read frame count", lg_n, 4);
        chk_frame(0, 1'b0, 5'h12, 5'd0, 16'h0, "R4");
        chk_frame(1, 1'b1, 5'h12, 5'd0, 16'h9867, "R3");
        chk_frame(2, 1'b0, 5'h12, 5'd0, 16'h0, "R4");
        chk_frame(3, 1'b0, 5'h12, 5'd1, 16'h0, "R4");
        chk(!e && rd == 16'hA5C3, "R4", "window read data", rd, 16'hA5C3);
    endtask

    task automatic t_busy_retry();
        bit e; logic [15:0] rd;
        cfg_bus_addr = 5'h05;
        busy_left = 3;
        busy_after_cmd = 1;
        do_req(1'b1, 5'd1, 5'd2, 16'h0F0F, e, rd);
        busy_after_cmd = 0;
        chk(lg_n == 8, "R6", "frames with busy retries", lg_n, 8);
        chk_frame(4, 1'b1, 5'h05, 5'd1, 16'h0F0F, "R6");
        for (int i = 0; i < 3; i++)
            chk(lg_start[i+1] - lg_end[i] == TICKS + 1, "R7", "retry spacing",
                lg_start[i+1] - lg_end[i], TICKS + 1);
        chk(lg_start[7] - lg_end[6] == TICKS + 1, "R7", "post-command retry spacing",
            lg_start[7] - lg_end[6], TICKS + 1);
        chk(!e, "R6", "busy retry succeeds", e, 0);
    endtask

    task automatic t_err_poll();
        bit e; logic [15:0] rd;
        cfg_bus_addr = 5'h05;
        err_polls = 2;
        do_req(1'b1, 5'd1, 5'd3, 16'h5555, e, rd);
        chk(lg_n == 6, "R6", "raw poll errors retried", lg_n, 6);
        chk_frame(3, 1'b1, 5'h05, 5'd1, 16'h5555, "R6");
        chk(!e && tmem[{5'd1, 5'd3}] == 16'h5555, "R6", "write after errored polls",
            tmem[{5'd1, 5'd3}], 16'h5555);
    endtask

    task automatic t_timeout();
        bit e; logic [15:0] rd;
        bit extra;
        cfg_bus_addr = 5'h05;
        busy_left = 100000;
        do_req(1'b0, 5'd1, 5'd2, 16'h0, e, rd);
        chk(e == 1'b1, "R8", "timeout error", e, 1);
        chk(rd == 16'h0, "R11", "rdata zero on error", rd, 0);
        chk(lg_n == LIMIT, "R8", "poll attempts", lg_n, LIMIT);
        chk(lg_reg[LIMIT-1] == 5'd0 && lg_w[LIMIT-1] == 1'b0, "R8",
            "last frame is a poll", lg_reg[LIMIT-1], 0);
        extra = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (mdio_valid) extra = 1'b1;
        end
        chk(!extra, "R8", "no frame after timeout", extra, 0);
        busy_left = 0;
    endtask

    task automatic t_data_err();
        bit e; logic [15:0] rd;
        cfg_bus_addr = 5'h05;
        err_data_wr = 1'b1;
        do_req(1'b1, 5'd4, 5'd4, 16'h7777, e, rd);
        err_data_wr = 1'b0;
        chk(e == 1'b1, "R9", "data write error reported", e, 1);
        chk(lg_n == 2, "R9", "stop after raw error", lg_n, 2);
        chk(tmem[{5'd4, 5'd4}] == 16'h0, "R9", "target unchanged",
            tmem[{5'd4, 5'd4}], 0);
    endtask

    task automatic t_ignored();
        int n;
        bit extra;
        cfg_bus_addr = 5'h05;
        busy_left = 2;
        lg_n = 0;
        @(negedge clk);
        req_write = 1'b1; req_dev = 5'd5; req_reg = 5'd2; req_wdata = 16'h2222;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        req_write = 1'b1; req_dev = 5'd6; req_reg = 5'd2; req_wdata = 16'hBEEF;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!rsp_done && n < 5000) begin @(negedge clk); n++; end
        extra = 1'b0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (mdio_valid) extra = 1'b1;
        end
        chk(!extra && lg_n == 6, "R10", "busy-time request ignored", lg_n, 6);
        chk(tmem[{5'd6, 5'd2}] == 16'h0, "R10", "ignored write not done",
            tmem[{5'd6, 5'd2}], 0);
        chk(tmem[{5'd5, 5'd2}] == 16'h2222, "R10", "accepted write done",
            tmem[{5'd5, 5'd2}], 16'h2222);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL R10 watchdog actual=hung expected=complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_direct();
        t_win_write();
        t_win_read();
        t_busy_retry();
        t_err_poll();
        t_timeout();
        t_data_err();
        t_ignored();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule